// File: doc/BRIEF.md
# One-Shot Message Sender with Start and End Markers

The block sends one message held in a small local buffer over a byte-wide output, one byte per clock. A host arms it with a single-cycle pulse. The block then marks the beginning of the message with a one-cycle pulse on a start line. It reads the buffer in ascending address order and puts one byte on the data bus in each clock. After the last byte it marks completion with a one-cycle pulse on an end line.

The block is one-shot. When a message completes, the hardware drops its own run bit, sets a buffer-empty flag and raises a sticky interrupt. It then waits until the host arms it again. The host must clear the interrupt explicitly. The message length comes from a byte-count input that is captured when the arm pulse is accepted. A length of zero gives a start pulse followed directly by an end pulse.

Control is a four-state machine:
- **IDLE**: waits for the arm pulse. Transition *arm accepted* goes to START.
- **START**: the start pulse cycle. Transition *empty message* (captured length zero) goes to END. Transition *first byte* goes to SEND.
- **SEND**: one byte per cycle. Transition *more bytes* stays in SEND. Transition *last byte sent* goes to END.
- **END**: the end pulse cycle. Transition *finished* returns to IDLE.

Top module: `msg_signaler`

## Requirements
- R1: An arm pulse sampled while idle makes start_mark, and only start_mark, go high in the next cycle; in that cycle run_active is 1 and buf_empty is 0.
- R2: start_mark is high for exactly one cycle, and tx_data is 0 in that cycle.
- R3: For a captured length N ≥ 1, the N cycles after the start pulse carry buffer bytes at addresses 0, 1, …, N-1 on tx_data, in that order, one per cycle.
- R4: end_mark is high for exactly one cycle, in the cycle right after the last byte (or right after the start pulse when N = 0).
- R5: In the end pulse cycle buf_empty is 1, irq is 1 and run_active is 0.
- R6: irq stays 1 until a cycle in which irq_clear is sampled high; if completion and irq_clear coincide, irq is set.
- R7: A byte count of 0 gives a start pulse, then the end pulse in the next cycle, with no data cycle between them.
- R8: An arm pulse sampled in any state other than idle (start, sending or end cycle) is ignored: the running message is unchanged and no new start pulse follows.
- R9: tx_data is 0 in every cycle that does not carry a message byte, and nothing is sent after completion until the next accepted arm pulse.
- R10: After reset, tx_data, start_mark, end_mark, run_active and irq are 0 and buf_empty is 1.
- R11: byte_count is captured only when the arm pulse is accepted; later changes to it have no effect on the running message.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm_set | input | 1 | Host pulse that sets the run bit and starts a message |
| irq_clear | input | 1 | Host pulse that clears the interrupt |
| byte_count | input | CNT_W (7) | Message length in bytes, 0 to 2**ADDR_W |
| buf_rd_addr | output | ADDR_W (6) | Read address into the local message buffer |
| buf_rd_data | input | DATA_W (8) | Buffer byte at buf_rd_addr, combinational read |
| tx_data | output | DATA_W (8) | Outgoing byte stream, 0 when not sending |
| start_mark | output | 1 | One-cycle start-of-message pulse |
| end_mark | output | 1 | One-cycle end-of-message pulse |
| run_active | output | 1 | Run bit; set on arm, cleared by hardware on completion |
| buf_empty | output | 1 | Buffer-empty status; cleared on arm, set on completion |
| irq | output | 1 | Sticky completion interrupt |

## Verification
The assertions assume that the buffer behaves as a combinational read port. They also assume that byte_count never exceeds 2**ADDR_W, so the read address never wraps within a message. The assertion tying start_mark to a prior arm pulse relies on arm_set being an ordinary synchronous input after reset. The stimulus draws lengths from 0 to the buffer depth and fills the buffer before each arm. It fires stray arm pulses only at chosen cycles inside or right after a message, and it scrambles byte_count once the arm has been accepted.

// File: rtl/msg_signaler_pkg.sv
package msg_signaler_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_SEND  = 2'd2,
        ST_END   = 2'd3
    } msg_state_e;

endpackage

// File: rtl/msg_seq_fsm.sv
module msg_seq_fsm
    import msg_signaler_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       arm_set,
    input  logic       len_zero,
    input  logic       last_byte,
    output msg_state_e state_q,
    output msg_state_e state_d
);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (arm_set) state_d = ST_START;
            ST_START: state_d = len_zero ? ST_END : ST_SEND;
            ST_SEND:  if (last_byte) state_d = ST_END;
            ST_END:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

endmodule

// File: rtl/msg_byte_ctr.sv
module msg_byte_ctr #(
    parameter int ADDR_W = 6,
    parameter int CNT_W  = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              load_byte,
    input  logic [CNT_W-1:0]  byte_count,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              len_zero,
    output logic              last_byte
);

    logic [CNT_W-1:0] len_q;
    logic [CNT_W-1:0] sent_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q  <= '0;
            sent_q <= '0;
        end else if (accept) begin
            len_q  <= byte_count;
            sent_q <= '0;
        end else if (load_byte) begin
            sent_q <= sent_q + 1'b1;
        end
    end

    assign rd_addr   = sent_q[ADDR_W-1:0];
    assign len_zero  = (len_q == '0);
    assign last_byte = (sent_q == len_q);

endmodule

// File: rtl/msg_status.sv
module msg_status (
    input  logic clk,
    input  logic rst_n,
    input  logic accept,
    input  logic finish,
    input  logic irq_clear,
    output logic run_q,
    output logic empty_q,
    output logic irq_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q   <= 1'b0;
            empty_q <= 1'b1;
            irq_q   <= 1'b0;
        end else begin
            if (accept) begin
                run_q   <= 1'b1;
                empty_q <= 1'b0;
            end else if (finish) begin
                run_q   <= 1'b0;
                empty_q <= 1'b1;
            end
            if (finish)         irq_q <= 1'b1;
            else if (irq_clear) irq_q <= 1'b0;
        end
    end

endmodule

// File: rtl/msg_signaler.sv
module msg_signaler
    import msg_signaler_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 6,
    parameter int CNT_W  = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm_set,
    input  logic              irq_clear,
    input  logic [CNT_W-1:0]  byte_count,
    output logic [ADDR_W-1:0] buf_rd_addr,
    input  logic [DATA_W-1:0] buf_rd_data,
    output logic [DATA_W-1:0] tx_data,
    output logic              start_mark,
    output logic              end_mark,
    output logic              run_active,
    output logic              buf_empty,
    output logic              irq
);

    msg_state_e state_q;
    msg_state_e state_d;
    logic       len_zero;
    logic       last_byte;
    logic       accept;
    logic       load_byte;
    logic       finish;
    logic [DATA_W-1:0] tx_q;

    assign accept    = (state_q == ST_IDLE) && arm_set;
    assign load_byte = (state_d == ST_SEND);
    assign finish    = (state_d == ST_END);

    msg_seq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm_set   (arm_set),
        .len_zero  (len_zero),
        .last_byte (last_byte),
        .state_q   (state_q),
        .state_d   (state_d)
    );

    msg_byte_ctr #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W)
    ) u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .load_byte  (load_byte),
        .byte_count (byte_count),
        .rd_addr    (buf_rd_addr),
        .len_zero   (len_zero),
        .last_byte  (last_byte)
    );

    msg_status u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .finish    (finish),
        .irq_clear (irq_clear),
        .run_q     (run_active),
        .empty_q   (buf_empty),
        .irq_q     (irq)
    );

    // data register: holds a byte only while sending
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         tx_q <= '0;
        else if (load_byte) tx_q <= buf_rd_data;
        else                tx_q <= '0;
    end

    // output decode
    always_comb begin
        start_mark = 1'b0;
        end_mark   = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_START: start_mark = 1'b1;
            ST_SEND:  ;
            ST_END:   end_mark = 1'b1;
        endcase
        tx_data = tx_q;
    end

endmodule

// File: rtl/msg_signaler_chk.sv
module msg_signaler_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              arm_set,
    input logic              irq_clear,
    input logic [DATA_W-1:0] tx_data,
    input logic              start_mark,
    input logic              end_mark,
    input logic              run_active,
    input logic              buf_empty,
    input logic              irq
);

    AST_START_FROM_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        start_mark |-> $past(arm_set) && run_active && !buf_empty);          // R1
    AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        start_mark |=> !start_mark);                                          // R2
    AST_START_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        start_mark |-> tx_data == '0);                                        // R2
    AST_END_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        end_mark |=> !end_mark && !start_mark);                               // R4
    AST_END_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        end_mark |-> buf_empty && irq && !run_active);                        // R5
    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_clear) |=> irq);                                         // R6
    AST_MARKS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_mark && end_mark));                                           // R4
    AST_QUIET_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        !run_active |-> tx_data == '0);                                       // R9

endmodule

bind msg_signaler msg_signaler_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .arm_set    (arm_set),
    .irq_clear  (irq_clear),
    .tx_data    (tx_data),
    .start_mark (start_mark),
    .end_mark   (end_mark),
    .run_active (run_active),
    .buf_empty  (buf_empty),
    .irq        (irq)
);

// File: tb/msg_signaler_bench.sv
module msg_signaler_bench;

    localparam int CLK_PERIOD = 10;
    localparam int DATA_W     = 8;
    localparam int ADDR_W     = 6;
    localparam int CNT_W      = ADDR_W + 1;
    localparam int DEPTH      = 1 << ADDR_W;
    localparam int WATCHDOG   = 150000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              arm_set = 1'b0;
    logic              irq_clear = 1'b0;
    logic [CNT_W-1:0]  byte_count = '0;
    logic [ADDR_W-1:0] buf_rd_addr;
    logic [DATA_W-1:0] buf_rd_data;
    logic [DATA_W-1:0] tx_data;
    logic              start_mark, end_mark, run_active, buf_empty, irq;

    logic [DATA_W-1:0] mem [DEPTH];
    int  n_vec  = 0;
    int  n_fail = 0;
    bit  exp_irq = 1'b0;
    bit  done = 1'b0;

    assign buf_rd_data = mem[buf_rd_addr];

    always #(CLK_PERIOD/2) clk = ~clk;

    msg_signaler #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_msg_signaler (
        .clk(clk), .rst_n(rst_n), .arm_set(arm_set), .irq_clear(irq_clear),
        .byte_count(byte_count), .buf_rd_addr(buf_rd_addr), .buf_rd_data(buf_rd_data),
        .tx_data(tx_data), .start_mark(start_mark), .end_mark(end_mark),
        .run_active(run_active), .buf_empty(buf_empty), .irq(irq)
    );

    // expected byte in cycle c after the arm edge (c = 1 .. n carry data)
    function automatic logic [DATA_W-1:0] exp_tx(int c, int n);
        if (c >= 1 && c <= n) return mem[c-1];
        return '0;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // arm_at: cycle index (0 = start cycle, n+1 = end cycle) for a stray arm, -1 none
    task automatic run_msg(int n, int arm_at, bit clr_at_end, bit clr_after);
        for (int i = 0; i < DEPTH; i++) mem[i] = DATA_W'($urandom);
        @(negedge clk);
        byte_count = CNT_W'(n);
        arm_set    = 1'b1;
        @(negedge clk);
        arm_set    = 1'b0;
        byte_count = CNT_W'($urandom_range(0, DEPTH));           // R11 scramble
        chk("R1 start_mark", 32'(start_mark), 1);
        chk("R1 run_active", 32'(run_active), 1);
        chk("R1 buf_empty",  32'(buf_empty), 0);
        chk("R2 tx_data in start", 32'(tx_data), 0);
        chk("R6 irq held", 32'(irq), 32'(exp_irq));
        for (int c = 0; c <= n + 1; c++) begin
            arm_set   = (c == arm_at);
            irq_clear = clr_at_end && (c == n);
            @(negedge clk);
            arm_set   = 1'b0;
            irq_clear = 1'b0;
            if (c + 1 <= n) begin
                chk("R3 byte", 32'(tx_data), 32'(exp_tx(c + 1, n)));
                chk("R2 start single", 32'(start_mark), 0);
                chk("R4 no early end", 32'(end_mark), 0);
                chk("R11 run through", 32'(run_active), 1);
            end else if (c + 1 == n + 1) begin
                exp_irq = 1'b1;
                chk(n == 0 ? "R7 end after start" : "R4 end_mark", 32'(end_mark), 1);
                chk("R5 buf_empty", 32'(buf_empty), 1);
                chk("R5 irq", 32'(irq), 1);
                chk("R5 run_active", 32'(run_active), 0);
                chk("R9 tx in end", 32'(tx_data), 0);
            end else begin
                chk("R8 no restart", 32'(start_mark), 0);
                chk("R4 end single", 32'(end_mark), 0);
                chk("R9 stopped", 32'(run_active), 0);
                chk("R9 tx quiet", 32'(tx_data), 0);
                chk("R6 irq sticky", 32'(irq), 32'(exp_irq));
            end
        end
        repeat (3) begin
            @(negedge clk);
            chk("R9 idle tx", 32'(tx_data), 0);
            chk("R8 idle start", 32'(start_mark), 0);
        end
        if (clr_after) begin
            irq_clear = 1'b1;
            @(negedge clk);
            irq_clear = 1'b0;
            exp_irq   = 1'b0;
            chk("R6 irq cleared", 32'(irq), 0);
        end
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < DEPTH; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        chk("R10 tx_data", 32'(tx_data), 0);
        chk("R10 start", 32'(start_mark), 0);
        chk("R10 end", 32'(end_mark), 0);
        chk("R10 run", 32'(run_active), 0);
        chk("R10 empty", 32'(buf_empty), 1);
        chk("R10 irq", 32'(irq), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 after release", 32'(start_mark), 0);

        run_msg(1, -1, 1'b0, 1'b1);          // single byte
        run_msg(0, -1, 1'b0, 1'b1);          // R7 empty message
        run_msg(0, 1, 1'b0, 1'b0);           // R8 arm in end cycle of empty message
        run_msg(DEPTH, -1, 1'b0, 1'b1);      // full buffer
        run_msg(3, -1, 1'b1, 1'b0);          // R6 clear coincides with completion
        run_msg(5, 2, 1'b0, 1'b1);           // R8 arm while sending
        run_msg(4, 0, 1'b0, 1'b0);           // R8 arm in start cycle
        run_msg(4, 5, 1'b0, 1'b1);           // R8 arm in end cycle
        for (int m = 0; m < 24; m++) begin
            int n;
            int a;
            n = $urandom_range(0, DEPTH);
            a = ($urandom_range(0, 2) == 0) ? -1 : $urandom_range(0, n + 1);
            run_msg(n, a, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule